// File: doc/BRIEF.md
# Logic Analyzer Trigger Term Unit

This block checks every captured 32-bit sample against a bank of programmable conditions and hands one flag per condition to a downstream trigger sequencer. There are ten masked pattern comparators, two inclusive range comparators, two edge detectors that compare the current sample with the previous valid sample, and two counting timers. The sequencer starts, stops and clears the timers through strobe inputs.

All targets, masks, limits, edge codes and timer reload values are written through a simple register-write port (write enable, address, data). The sixteen flags are registered together whenever a sample is marked valid, so the sequencer sees a complete, consistent term vector one clock after each valid sample.

Top module: `trig_term_unit`

## Requirements
- R1: Pattern term k (hit bit k, k = 0..9) is 1 when ((sample XOR target_k) AND mask_k) is zero; a mask bit of 0 makes that channel a don't-care.
- R2: Range term r (hit bit 10 + r) is 1 when low_r <= sample <= high_r, unsigned, with both limits included.
- R3: Edge term e (hit bit 12 + e) is 1 only when every channel i meets its 2-bit code held in bits [2i+1:2i] of that detector's 64-bit code: 00 no change, 01 rising (0 to 1), 10 falling (1 to 0), 11 any change.
- R4: After reset, the first valid sample produces no edge hit in either edge term.
- R5: Edge detection compares against the previous valid sample; sample values present while sample_valid is low are ignored.
- R6: Timer t (hit bit 14 + t) counts clock cycles while running after a start strobe; its expiry flag sets on the max(reload,1)-th counting edge and counting then halts.
- R7: A set expiry flag stays set until a clear strobe for that timer; clear resets count, running state and flag, and wins over stop and start.
- R8: A stop strobe pauses the timer and keeps its count; a later start resumes from that count.
- R9: hit_valid is sample_valid delayed by one clock; hit_vec is loaded only on valid samples and holds its value otherwise.
- R10: Reset clears hit_vec, hit_valid, all configuration registers and all timers.
- R11: Register addresses: 0..9 pattern targets, 10..19 pattern masks, 20..21 range low limits, 22..23 range high limits, 24+2e+w edge code word w of detector e (word 0 holds channels 0..15, word 1 channels 16..31), 28..29 timer reload values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 32 | Register write data |
| sample_valid | input | 1 | Sample qualifier |
| sample | input | 32 | Captured sample |
| tmr_start | input | 2 | Per-timer start strobe |
| tmr_stop | input | 2 | Per-timer stop strobe |
| tmr_clear | input | 2 | Per-timer clear strobe |
| hit_valid | output | 1 | Term vector valid, one clock after sample_valid |
| hit_vec | output | 16 | Term flags: patterns, ranges, edges, timers (LSB first) |

## Verification
The properties assume that configuration is written while samples are not being judged against it and that strobes are single-cycle pulses from a synchronous source; the directed stimulus writes all registers before each scenario and pulses each strobe for exactly one clock. Timer properties take the clear strobe as dominant and make no claim about a start and stop in the same cycle, which the stimulus never produces. Edge properties assume sample values are only meaningful when qualified, so the bench deliberately drives changing data with the qualifier low to show it is ignored.

// File: rtl/trig_term_pkg.sv
package trig_term_pkg;

    typedef enum logic [1:0] {
        EDGE_STEADY = 2'b00,
        EDGE_RISE   = 2'b01,
        EDGE_FALL   = 2'b10,
        EDGE_ANY    = 2'b11
    } edge_code_e;

    typedef struct packed {
        logic clr;
        logic halt;
        logic go;
    } tmr_cmd_t;

    function automatic logic chan_edge_ok(edge_code_e code, logic prev_b, logic cur_b);
        logic ok;
        case (code)
            EDGE_STEADY: ok = (prev_b == cur_b);
            EDGE_RISE:   ok = (!prev_b && cur_b);
            EDGE_FALL:   ok = (prev_b && !cur_b);
            default:     ok = (prev_b != cur_b);
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs #(
    parameter int DW   = 32,
    parameter int NPAT = 10,
    parameter int NRNG = 2,
    parameter int NEDG = 2,
    parameter int NTMR = 2,
    parameter int TW   = 32,
    parameter int AW   = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [AW-1:0]              addr,
    input  logic [DW-1:0]              wdata,
    output logic [NPAT-1:0][DW-1:0]    pat_tgt,
    output logic [NPAT-1:0][DW-1:0]    pat_msk,
    output logic [NRNG-1:0][DW-1:0]    rng_lo,
    output logic [NRNG-1:0][DW-1:0]    rng_hi,
    output logic [NEDG-1:0][2*DW-1:0]  edge_code,
    output logic [NTMR-1:0][TW-1:0]    tmr_reload
);
    localparam int TGT_B = 0;
    localparam int MSK_B = TGT_B + NPAT;
    localparam int RLO_B = MSK_B + NPAT;
    localparam int RHI_B = RLO_B + NRNG;
    localparam int EDG_B = RHI_B + NRNG;
    localparam int EWORDS = 2;
    localparam int TMR_B = EDG_B + NEDG * EWORDS;

    for (genvar k = 0; k < NPAT; k++) begin : g_pat
        always_ff @(posedge clk) begin
            if (rst) begin
                pat_tgt[k] <= '0;
                pat_msk[k] <= '0;
            end else if (we) begin
                if (addr == AW'(TGT_B + k)) pat_tgt[k] <= wdata;
                if (addr == AW'(MSK_B + k)) pat_msk[k] <= wdata;
            end
        end

        assert_tgt_write_R11: assert property (@(posedge clk) disable iff (rst)
            (we && addr == AW'(TGT_B + k)) |=> (pat_tgt[k] == $past(wdata)));
    end

    for (genvar r = 0; r < NRNG; r++) begin : g_rng
        always_ff @(posedge clk) begin
            if (rst) begin
                rng_lo[r] <= '0;
                rng_hi[r] <= '0;
            end else if (we) begin
                if (addr == AW'(RLO_B + r)) rng_lo[r] <= wdata;
                if (addr == AW'(RHI_B + r)) rng_hi[r] <= wdata;
            end
        end
    end

    for (genvar e = 0; e < NEDG; e++) begin : g_edg
        always_ff @(posedge clk) begin
            if (rst) begin
                edge_code[e] <= '0;
            end else if (we) begin
                for (int w = 0; w < EWORDS; w++) begin
                    if (addr == AW'(EDG_B + e * EWORDS + w))
                        edge_code[e][w*DW +: DW] <= wdata;
                end
            end
        end
    end

    for (genvar t = 0; t < NTMR; t++) begin : g_tmr
        always_ff @(posedge clk) begin
            if (rst) begin
                tmr_reload[t] <= '0;
            end else if (we && addr == AW'(TMR_B + t)) begin
                tmr_reload[t] <= TW'(wdata);
            end
        end
    end

endmodule

// File: rtl/trig_match.sv
module trig_match #(
    parameter int DW   = 32,
    parameter int NPAT = 10,
    parameter int NRNG = 2
) (
    input  logic [DW-1:0]            sample,
    input  logic [NPAT-1:0][DW-1:0]  pat_tgt,
    input  logic [NPAT-1:0][DW-1:0]  pat_msk,
    input  logic [NRNG-1:0][DW-1:0]  rng_lo,
    input  logic [NRNG-1:0][DW-1:0]  rng_hi,
    output logic [NPAT-1:0]          pat_hit,
    output logic [NRNG-1:0]          rng_hit
);
    for (genvar k = 0; k < NPAT; k++) begin : g_pat
        logic [DW-1:0] diff;
        assign diff       = (sample ^ pat_tgt[k]) & pat_msk[k];
        assign pat_hit[k] = (diff == '0);
    end

    for (genvar r = 0; r < NRNG; r++) begin : g_rng
        logic above_lo;
        logic below_hi;
        assign above_lo   = (sample >= rng_lo[r]);
        assign below_hi   = (sample <= rng_hi[r]);
        assign rng_hit[r] = above_lo && below_hi;
    end

endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det
    import trig_term_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NEDG = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sample_valid,
    input  logic [DW-1:0]              sample,
    input  logic [NEDG-1:0][2*DW-1:0]  edge_code,
    output logic [NEDG-1:0]            edge_hit
);
    logic [DW-1:0] prev_q;
    logic          prev_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            prev_ok <= 1'b0;
        end else if (sample_valid) begin
            prev_q  <= sample;
            prev_ok <= 1'b1;
        end
    end

    for (genvar e = 0; e < NEDG; e++) begin : g_det
        logic all_ok;
        always_comb begin
            all_ok = 1'b1;
            for (int i = 0; i < DW; i++) begin
                all_ok = all_ok &&
                    chan_edge_ok(edge_code_e'(edge_code[e][2*i +: 2]), prev_q[i], sample[i]);
            end
        end
        assign edge_hit[e] = prev_ok && all_ok;
    end

    // R5: history only advances on a qualified sample
    assert_prev_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> $stable(prev_q));

    assert_prev_arm_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(prev_ok) |-> $past(sample_valid));

endmodule

// File: rtl/trig_timer.sv
module trig_timer
    import trig_term_pkg::*;
#(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  tmr_cmd_t      cmd,
    input  logic [TW-1:0] reload,
    output logic          expired
);
    logic [TW-1:0] cnt;
    logic          running;
    logic [TW:0]   cnt_nxt;

    assign cnt_nxt = {1'b0, cnt} + (TW+1)'(1);

    always_ff @(posedge clk) begin
        if (rst || cmd.clr) begin
            cnt     <= '0;
            running <= 1'b0;
            expired <= 1'b0;
        end else if (cmd.halt) begin
            running <= 1'b0;
        end else begin
            if (cmd.go && !expired) running <= 1'b1;
            if (running) begin
                cnt <= cnt_nxt[TW-1:0];
                if (cnt_nxt >= {1'b0, reload}) begin
                    expired <= 1'b1;
                    running <= 1'b0;
                end
            end
        end
    end

    assert_expiry_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (expired && !cmd.clr) |=> expired);

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        cmd.clr |=> (!expired && cnt == '0));

    assert_expiry_source_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(expired) |-> $past(running));

    assert_pause_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd.halt && !cmd.clr) |=> $stable(cnt));

endmodule

// File: rtl/trig_term_unit.sv
module trig_term_unit
    import trig_term_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NPAT = 10,
    parameter int NRNG = 2,
    parameter int NEDG = 2,
    parameter int NTMR = 2,
    parameter int TW   = 32,
    localparam int NHIT = NPAT + NRNG + NEDG + NTMR,
    localparam int NREG = 2 * NPAT + 2 * NRNG + 2 * NEDG + NTMR,
    localparam int AW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [DW-1:0]   cfg_wdata,
    input  logic            sample_valid,
    input  logic [DW-1:0]   sample,
    input  logic [NTMR-1:0] tmr_start,
    input  logic [NTMR-1:0] tmr_stop,
    input  logic [NTMR-1:0] tmr_clear,
    output logic            hit_valid,
    output logic [NHIT-1:0] hit_vec
);
    logic [NPAT-1:0][DW-1:0]   pat_tgt;
    logic [NPAT-1:0][DW-1:0]   pat_msk;
    logic [NRNG-1:0][DW-1:0]   rng_lo;
    logic [NRNG-1:0][DW-1:0]   rng_hi;
    logic [NEDG-1:0][2*DW-1:0] edge_code;
    logic [NTMR-1:0][TW-1:0]   tmr_reload;

    logic [NPAT-1:0] pat_hit;
    logic [NRNG-1:0] rng_hit;
    logic [NEDG-1:0] edge_hit;
    logic [NTMR-1:0] tmr_exp;
    logic [NHIT-1:0] hit_d;

    trig_cfg_regs #(
        .DW(DW), .NPAT(NPAT), .NRNG(NRNG), .NEDG(NEDG), .NTMR(NTMR), .TW(TW), .AW(AW)
    ) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .pat_tgt(pat_tgt), .pat_msk(pat_msk), .rng_lo(rng_lo), .rng_hi(rng_hi),
        .edge_code(edge_code), .tmr_reload(tmr_reload)
    );

    trig_match #(.DW(DW), .NPAT(NPAT), .NRNG(NRNG)) u_match (
        .sample(sample), .pat_tgt(pat_tgt), .pat_msk(pat_msk),
        .rng_lo(rng_lo), .rng_hi(rng_hi), .pat_hit(pat_hit), .rng_hit(rng_hit)
    );

    trig_edge_det #(.DW(DW), .NEDG(NEDG)) u_edge (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample(sample),
        .edge_code(edge_code), .edge_hit(edge_hit)
    );

    for (genvar t = 0; t < NTMR; t++) begin : g_tmr
        tmr_cmd_t cmd;
        assign cmd = '{clr: tmr_clear[t], halt: tmr_stop[t], go: tmr_start[t]};
        trig_timer #(.TW(TW)) u_tmr (
            .clk(clk), .rst(rst), .cmd(cmd), .reload(tmr_reload[t]), .expired(tmr_exp[t])
        );
    end

    assign hit_d = {tmr_exp, edge_hit, rng_hit, pat_hit};

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_valid <= 1'b0;
            hit_vec   <= '0;
        end else begin
            hit_valid <= sample_valid;
            if (sample_valid) hit_vec <= hit_d;
        end
    end

    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> hit_valid);

    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> (!hit_valid && $stable(hit_vec)));

endmodule

// File: tb/tb_trig_term_unit.sv
module tb_trig_term_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [4:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        sample_valid;
    logic [31:0] sample;
    logic [1:0]  tmr_start, tmr_stop, tmr_clear;
    logic        hit_valid;
    logic [15:0] hit_vec;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    trig_term_unit dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .sample_valid(sample_valid), .sample(sample),
        .tmr_start(tmr_start), .tmr_stop(tmr_stop), .tmr_clear(tmr_clear),
        .hit_valid(hit_valid), .hit_vec(hit_vec)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [31:0] s);
        @(negedge clk);
        sample = s; sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic strobe(input int kind, input logic [1:0] m);
        @(negedge clk);
        if (kind == 0) tmr_start = m; else if (kind == 1) tmr_stop = m; else tmr_clear = m;
        @(negedge clk);
        tmr_start = '0; tmr_stop = '0; tmr_clear = '0;
    endtask

    task automatic t_reset();
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        sample_valid = 1'b0; sample = '0; tmr_start = '0; tmr_stop = '0; tmr_clear = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "hit_valid after reset", 32'(hit_valid), 32'd0);
        chk("R10", "hit_vec after reset", 32'(hit_vec), 32'd0);
        send(32'h5);
        chk("R9", "hit_valid one clock after sample", 32'(hit_valid), 32'd1);
        chk("R10", "zero masks make every pattern hit", 32'(hit_vec[9:0]), 32'h3FF);
        chk("R10", "zeroed limits reject 5", 32'(hit_vec[11:10]), 32'd0);
        chk("R4", "no edge hit on first sample", 32'(hit_vec[13:12]), 32'd0);
        @(negedge clk);
        chk("R9", "hit_valid drops", 32'(hit_valid), 32'd0);
        send(32'h5);
        chk("R3", "steady codes hit on unchanged sample", 32'(hit_vec[13:12]), 32'h3);
    endtask

    task automatic t_pattern();
        wr(0, 32'hDEADBEEF); wr(10, 32'hFFFFFFFF);
        wr(1, 32'h000000FF); wr(11, 32'h000000FF);
        send(32'hDEADBEEF);
        chk("R1", "full-mask match", 32'(hit_vec[1:0]), 32'b01);
        send(32'h123456FF);
        chk("R1", "low byte match, upper bits ignored", 32'(hit_vec[1:0]), 32'b10);
        send(32'hDEADBEEE);
        chk("R1", "single bit mismatch", 32'(hit_vec[0]), 32'd0);
        chk("R1", "unmasked terms still hit", 32'(hit_vec[9:2]), 32'hFF);
    endtask

    task automatic t_range();
        wr(20, 32'd100); wr(22, 32'd200);
        send(32'd99);  chk("R2", "below low limit", 32'(hit_vec[10]), 32'd0);
        send(32'd100); chk("R2", "at low limit", 32'(hit_vec[10]), 32'd1);
        send(32'd200); chk("R2", "at high limit", 32'(hit_vec[10]), 32'd1);
        send(32'd201); chk("R2", "above high limit", 32'(hit_vec[10]), 32'd0);
        send(32'd0);   chk("R2", "degenerate 0..0 window", 32'(hit_vec[11]), 32'd1);
    endtask

    task automatic t_edge();
        // detector 0: ch0 rising, ch31 rising; detector 1: ch0 any, ch3 falling
        wr(24, 32'h00000001); wr(25, 32'h40000000);
        wr(26, 32'h00000083); wr(27, 32'h00000000);
        send(32'h00000000);
        send(32'h80000001);
        chk("R3", "two rising channels", 32'(hit_vec[12]), 32'd1);
        chk("R3", "fall code not met", 32'(hit_vec[13]), 32'd0);
        send(32'h80000009);
        chk("R3", "rise where fall wanted", 32'(hit_vec[13:12]), 32'd0);
        send(32'h80000000);
        chk("R3", "fall on ch3 with any-change on ch0", 32'(hit_vec[13:12]), 32'b10);
    endtask

    task automatic t_invalid();
        logic [15:0] held;
        send(32'h00000000);
        held = hit_vec;
        @(negedge clk);
        sample = 32'h80000001;
        repeat (3) @(negedge clk);
        chk("R9", "hit_vec held while invalid", 32'(hit_vec), 32'(held));
        chk("R9", "hit_valid low while invalid", 32'(hit_valid), 32'd0);
        send(32'h80000001);
        chk("R5", "unqualified data not taken as history", 32'(hit_vec[12]), 32'd1);
    endtask

    task automatic t_timer();
        wr(28, 32'd5); wr(29, 32'd0);
        strobe(0, 2'b11);
        send(32'h0);
        chk("R6", "timer0 not yet expired", 32'(hit_vec[14]), 32'd0);
        chk("R6", "timer1 reload 0 expires after one edge", 32'(hit_vec[15]), 32'd1);
        repeat (20) @(negedge clk);
        send(32'h0);
        chk("R6", "timer0 expired", 32'(hit_vec[14]), 32'd1);
        chk("R7", "expiry held", 32'(hit_vec[15]), 32'd1);
        strobe(2, 2'b11);
        send(32'h0);
        chk("R7", "clear drops both flags", 32'(hit_vec[15:14]), 32'd0);
    endtask

    task automatic t_pause();
        strobe(0, 2'b01);
        strobe(1, 2'b01);
        repeat (20) @(negedge clk);
        send(32'h0);
        chk("R8", "paused timer does not expire", 32'(hit_vec[14]), 32'd0);
        strobe(0, 2'b01);
        repeat (10) @(negedge clk);
        send(32'h0);
        chk("R8", "resumed timer expires", 32'(hit_vec[14]), 32'd1);
    endtask

    initial begin
        t_reset();
        t_pattern();
        t_range();
        t_edge();
        t_invalid();
        t_timer();
        t_pause();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule